// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Multi-Word Lines

This block sits between a processor's load port and a slower word-wide main memory. It works on 32-bit byte addresses and keeps a small, direct-mapped array of lines. Each line has a valid flag, a tag and a parameterised number of 32-bit words. A read that finds its line present is answered in the same cycle. A read that misses raises a stall. The controller then fetches the whole line from main memory one word at a time and answers the stalled read once the line is complete.

The processor presents `req_valid` with `req_addr`. It holds both steady while `stall` is high and treats a cycle with `rsp_valid` high as the completion of its read. `rsp_hit` tells an immediate answer apart from one delivered after a refill.

Main memory accepts a one-cycle `mem_req` with a word address. It answers after a fixed number of cycles with a one-cycle `mem_rvalid` pulse. Only one read is outstanding at a time.

Top module: `dmc_cache`

## Requirements
- R1: Address bits [1:0] select a byte within a word and play no part in lookup. Two addresses that differ only in those bits return the same word and the same hit result.
- R2: With `WORDS` words per line and `SETS` lines, the address is split from the bottom up:
  - bits [1:0] are the byte offset;
  - the next log2(`WORDS`) bits are the word-in-line offset;
  - the next log2(`SETS`) bits are the set index;
  - the remaining upper bits are the tag.
  A read hits only when the indexed line is valid and its stored tag equals the address tag. A hit sets `rsp_valid` and `rsp_hit` in the request cycle, with `stall` low.
- R3: The returned word is the word of the line chosen by the word-in-line offset, equal to main memory's content at the address with bits [1:0] cleared.
- R4: On a miss, `stall` is high from the request cycle until the completing cycle, and `rsp_valid` stays low in every stalled cycle.
- R5: A refill issues exactly `WORDS` reads, one outstanding at a time. Each read waits for its `mem_rvalid` before the next `mem_req`. The read addresses are the line base plus 4·k for k = 0, 1, …, `WORDS`-1, in that order.
- R6: After the last refill word returns, the next cycle has `rsp_valid` high, `rsp_hit` low and `stall` low, and carries the requested word.
- R7: After a refill, reads of the other words of the same line hit. With 4 words by 2 sets, repeating 0x4, 0xC, 0x8 five times gives 1 miss in 15. With 1 word by 8 sets, the same sequence gives 3 misses.
- R8: A read whose set index matches a resident line but whose tag differs misses and replaces that line. Alternating 0x4 and 0x24 misses on every access in both configurations.
- R9: Reset clears every valid flag. Leaving reset, `stall`, `rsp_valid` and `mem_req` are low while no read is requested, and any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | 32 | Byte address of the read, held while stalled |
| stall | output | 1 | Read cannot complete this cycle |
| rsp_valid | output | 1 | Read completes this cycle |
| rsp_hit | output | 1 | Completion came from a resident line |
| rsp_data | output | 32 | Returned word |
| mem_req | output | 1 | One-cycle word read request to main memory |
| mem_addr | output | 32 | Word-aligned main memory read address |
| mem_rvalid | input | 1 | One-cycle pulse: read data present |
| mem_rdata | input | 32 | Main memory read data |

## Verification
The bench targets the following corner cases:
- The repeated 0x4/0xC/0x8 loop in both line sizes. Refilling only the requested word, or decoding the offset bits into the index, would change the miss count from 1 or 3.
- Alternating 0x4/0x24, which share a set. A lookup that ignored tags or skipped replacement would report false hits.
- Sub-word addresses such as 0x7. A design that used the byte bits would pick the wrong word or miss.
- Every refill, where the bench checks the order, alignment and number of memory reads.
- A reset after the cache is warm, which must make a resident line miss again.

Seeded random traffic over a small address window is compared against a bench model of valid and tag state.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BYTE_OFF_W = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RESP   = 2'd3
    } fill_state_t;

    // Width of a field that may be empty, widened to at least one bit
    function automatic int min1(input int n);
        return (n > 0) ? n : 1;
    endfunction

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] data;
    } word_wr_t;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int SETS = 2,
    parameter int SETW = 1,
    parameter int TAGW = 27
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SETW-1:0] rd_set,
    output logic            rd_valid,
    output logic [TAGW-1:0] rd_tag,
    input  logic            we,
    input  logic [SETW-1:0] wr_set,
    input  logic [TAGW-1:0] wr_tag
);

    logic [SETS-1:0] valid_q;
    logic [TAGW-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[wr_set] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_tag   = tag_q[rd_set];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int SETS   = 2,
    parameter int WORDS  = 4,
    parameter int SETW   = 1,
    parameter int OFFW_S = 2
) (
    input  logic              clk,
    input  logic [SETW-1:0]   rd_set,
    input  logic [OFFW_S-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  word_wr_t          wr,
    input  logic [SETW-1:0]   wr_set,
    input  logic [OFFW_S-1:0] wr_word
);

    logic [WORD_W-1:0] line_q [SETS][WORDS];

    always_ff @(posedge clk) begin
        if (wr.we) begin
            line_q[wr_set][wr_word] <= wr.data;
        end
    end

    // Word-in-line multiplexer
    assign rd_data = line_q[rd_set][rd_word];

endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
    import dmc_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int OFFW_S = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              hit,
    input  logic              mem_rvalid,
    output logic [OFFW_S-1:0] fill_idx,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic              data_we,
    output logic              tag_we
);

    localparam logic [OFFW_S-1:0] LAST_IDX = OFFW_S'(WORDS - 1);

    fill_state_t       state_q, state_d;
    logic [OFFW_S-1:0] cnt_q, cnt_d;
    logic              lookup_hit, lookup_miss, last_word;

    assign lookup_hit  = (state_q == ST_LOOKUP) && req_valid && hit;
    assign lookup_miss = (state_q == ST_LOOKUP) && req_valid && !hit;
    assign last_word   = (cnt_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (lookup_miss) begin
                    state_d = ST_ISSUE;
                    cnt_d   = '0;
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (last_word) begin
                        state_d = ST_RESP;
                    end else begin
                        state_d = ST_ISSUE;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            ST_RESP: state_d = ST_LOOKUP;
            default: state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign fill_idx  = cnt_q;
    assign mem_req   = (state_q == ST_ISSUE);
    assign data_we   = (state_q == ST_WAIT) && mem_rvalid;
    assign tag_we    = data_we && last_word;
    assign stall     = lookup_miss || (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign rsp_valid = lookup_hit || (state_q == ST_RESP);
    assign rsp_hit   = lookup_hit;

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int SETS  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        stall,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_data,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);

    localparam int OFFW   = $clog2(WORDS);
    localparam int OFFW_S = min1(OFFW);
    localparam int SETW   = $clog2(SETS);
    localparam int LOW_W  = OFFW + SETW + BYTE_OFF_W;
    localparam int TAGW   = ADDR_W - LOW_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << (OFFW + BYTE_OFF_W)) - 1);

    logic [SETW-1:0]   set_idx;
    logic [TAGW-1:0]   addr_tag, stored_tag;
    logic [OFFW_S-1:0] word_sel, fill_idx;
    logic              stored_valid, hit, data_we, tag_we;
    word_wr_t          wr;

    assign set_idx  = req_addr[OFFW + BYTE_OFF_W +: SETW];
    assign addr_tag = req_addr[ADDR_W-1 -: TAGW];

    generate
        if (OFFW > 0) begin : g_multi
            assign word_sel = req_addr[BYTE_OFF_W +: OFFW_S];
        end else begin : g_single
            assign word_sel = '0;
        end
    endgenerate

    dmc_tag_store #(.SETS(SETS), .SETW(SETW), .TAGW(TAGW)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (set_idx),
        .rd_valid (stored_valid),
        .rd_tag   (stored_tag),
        .we       (tag_we),
        .wr_set   (set_idx),
        .wr_tag   (addr_tag)
    );

    assign hit = stored_valid && (stored_tag == addr_tag);

    assign wr.we   = data_we;
    assign wr.data = mem_rdata;

    dmc_data_store #(.SETS(SETS), .WORDS(WORDS), .SETW(SETW), .OFFW_S(OFFW_S)) u_data (
        .clk     (clk),
        .rd_set  (set_idx),
        .rd_word (word_sel),
        .rd_data (rsp_data),
        .wr      (wr),
        .wr_set  (set_idx),
        .wr_word (fill_idx)
    );

    dmc_refill_ctrl #(.WORDS(WORDS), .OFFW_S(OFFW_S)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .hit        (hit),
        .mem_rvalid (mem_rvalid),
        .fill_idx   (fill_idx),
        .stall      (stall),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .mem_req    (mem_req),
        .data_we    (data_we),
        .tag_we     (tag_we)
    );

    assign mem_addr = (req_addr & LINE_MASK)
                    | {{(ADDR_W - OFFW_S - BYTE_OFF_W){1'b0}}, fill_idx, 2'b00};

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
    parameter int WORDS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        stall,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid
);

    localparam int LB = $clog2(WORDS) + 2;

    // R2: an immediate hit never stalls
    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_valid && !stall));

    // R4: no completion while stalled
    a_r4_stall_no_rsp: assert property (@(posedge clk) disable iff (rst)
        stall |-> !rsp_valid);

    // R4: a pending read that does not complete must be stalled
    a_r4_pending_stalls: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |-> stall);

    // R5: one outstanding read; requests are single-cycle
    a_r5_single_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R5: refill reads are word aligned and stay within the requested line
    a_r5_addr_in_line: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr[31:LB] == req_addr[31:LB]));

    // R6: a refill completion directly follows a returned memory word
    a_r6_resp_after_fill: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> $past(mem_rvalid));

endmodule

bind dmc_cache dmc_cache_chk #(.WORDS(WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .stall      (stall),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_cache_tb;

    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg = 1'b0;   // 0: 4 words x 2 sets, 1: 1 word x 8 sets
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic        s0, v0, h0, q0, s1, v1, h1, q1;
    logic [31:0] d0, a0, d1, a1;
    logic        stall_m, rspv_m, hit_m, mreq_m;
    logic [31:0] data_m, maddr_m;

    int checks = 0;
    int errors = 0;
    int exp_k  = 0;
    int fill_reads = 0;
    logic [31:0] cur_addr = '0;
    bit   mv [8];
    int   mt [8];

    always #2.5 clk = ~clk;

    dmc_cache #(.WORDS(4), .SETS(2)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid && !cfg), .req_addr(req_addr),
        .stall(s0), .rsp_valid(v0), .rsp_hit(h0), .rsp_data(d0),
        .mem_req(q0), .mem_addr(a0), .mem_rvalid(mem_rvalid && !cfg), .mem_rdata(mem_rdata));

    dmc_cache #(.WORDS(1), .SETS(8)) u_dut1 (
        .clk(clk), .rst(rst), .req_valid(req_valid && cfg), .req_addr(req_addr),
        .stall(s1), .rsp_valid(v1), .rsp_hit(h1), .rsp_data(d1),
        .mem_req(q1), .mem_addr(a1), .mem_rvalid(mem_rvalid && cfg), .mem_rdata(mem_rdata));

    assign stall_m = cfg ? s1 : s0;
    assign rspv_m  = cfg ? v1 : v0;
    assign hit_m   = cfg ? h1 : h0;
    assign data_m  = cfg ? d1 : d0;
    assign mreq_m  = cfg ? q1 : q0;
    assign maddr_m = cfg ? a1 : a0;

    function automatic logic [31:0] mword(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    endfunction

    function automatic int words_n();
        return cfg ? 1 : 4;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cfg %0d)", req, act, exp, cfg);
        end
    endtask

    // Main memory model: fixed latency, one-cycle valid pulse
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mreq_m && !rst) begin
                logic [31:0] lb, a;
                a  = maddr_m;
                lb = cfg ? (cur_addr & ~32'h3) : (cur_addr & ~32'hF);
                check(a == lb + 32'(4 * exp_k), "R5 refill address order", a, lb + 32'(4 * exp_k));
                exp_k++;
                fill_reads++;
                repeat (MEM_LAT - 1) @(negedge clk);
                mem_rdata  = mword(a);
                mem_rvalid = 1'b1;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            mv[i] = 1'b0;
            mt[i] = 0;
        end
    endtask

    task automatic access(input logic [31:0] a, output bit was_hit);
        int offw, setw, s, t;
        bit exp_hit, first_stall;
        offw = cfg ? 0 : 2;
        setw = cfg ? 3 : 1;
        s = int'((a >> (2 + offw)) & ((32'd1 << setw) - 1));
        t = int'(a >> (2 + offw + setw));
        exp_hit = mv[s] && (mt[s] == t);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cur_addr  = a;
        exp_k = 0;
        fill_reads = 0;
        #1;
        first_stall = stall_m;
        check(first_stall == !exp_hit, "R4 stall in request cycle", 32'(first_stall), 32'(!exp_hit));
        while (!rspv_m) begin
            check(stall_m, "R4 stall held until completion", 32'(stall_m), 32'd1);
            @(negedge clk);
            #1;
        end
        was_hit = hit_m;
        check(hit_m == exp_hit, "R2/R8 hit flag", 32'(hit_m), 32'(exp_hit));
        check(data_m == mword(a & ~32'h3), "R3 returned word", data_m, mword(a & ~32'h3));
        check(!stall_m, "R6 stall low at completion", 32'(stall_m), 32'd0);
        if (!exp_hit) begin
            check(fill_reads == words_n(), "R5 refill read count", 32'(fill_reads), 32'(words_n()));
            mv[s] = 1'b1;
            mt[s] = t;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit h;
        int misses;
        void'($urandom(32'd1234));
        for (int c = 0; c < 2; c++) begin
            cfg = c[0];
            do_reset();
            #1;
            check(!stall_m && !rspv_m && !mreq_m, "R9 idle outputs after reset",
                  {29'd0, stall_m, rspv_m, mreq_m}, 32'd0);

            // R7: spatial locality loop
            misses = 0;
            for (int r = 0; r < 5; r++) begin
                access(32'h4, h); misses += h ? 0 : 1;
                access(32'hC, h); misses += h ? 0 : 1;
                access(32'h8, h); misses += h ? 0 : 1;
            end
            check(misses == (cfg ? 3 : 1), "R7 miss count of loop", 32'(misses), cfg ? 32'd3 : 32'd1);

            // R1: byte offset bits ignored
            access(32'h7, h);
            check(h, "R1 sub-word address hits", 32'(h), 32'd1);

            // R8: same-set conflict
            misses = 0;
            for (int r = 0; r < 5; r++) begin
                access(32'h24, h); misses += h ? 0 : 1;
                access(32'h4, h);  misses += h ? 0 : 1;
            end
            check(misses == 10, "R8 conflict misses", 32'(misses), 32'd10);

            // R9: reset invalidates a warm line
            do_reset();
            access(32'h4, h);
            check(!h, "R9 miss after reset", 32'(h), 32'd0);

            // Random traffic against the bench model
            for (int i = 0; i < 60; i++) begin
                access($urandom % 128, h);
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        finish_run();
    end

endmodule